// File: doc/BRIEF.md
# SPI Register-Mapped GPIO Controller

This block is a serial-peripheral slave that owns the control registers of a 16-pin general-purpose I/O port. A host selects the block with an active-low chip select and sends two bytes: a command byte and then one data byte. The command byte carries a read flag and a six-bit register address. On a write, the second byte arrives from the host and is stored in the addressed register. On a read, the register value is shifted back to the host during the second byte. The serial clock idles low. All three serial inputs are brought into the fast system clock through two-flop synchronizers, and every action happens in that clock.

The stored configuration drives per-pin outputs: direction (1 = input), output level, float (three-state), pull-up enable and input inversion. It also drives the per-pin enables for a separate interrupt and filter block: interrupt enable, rising-edge enable, falling-edge enable and filter enable. Reading a pin-state register returns a merged view. Input pins give the pin value, XORed with the inversion bit. Output pins give the last level written. The block also raises a one-cycle clear strobe for that byte, so the interrupt logic can take its snapshot. The interrupt status byte pairs are read from an input of the block. None of the pins carries a stream, so every port is a plain level or strobe with no valid/ready handshake and no back-pressure.

Registers are byte-wide and come in low/high pairs: even address = pins 7..0, odd address = pins 15..8. The pair index is address/2: 0 pin state, 1 output level, 2 inversion, 3 direction, 4 pull-up, 5 interrupt enable, 6 float, 7 interrupt status, 8 rising enable, 9 falling enable, 10 filter enable.

Top module: `spi_gpio_ctrl`

## Requirements
- R1: The command byte arrives MSB first. Bit 7 = 1 means read and 0 means write. Bits 6:1 are the register address. Bit 0 has no effect.
- R2: On a write, the second byte (MSB first) replaces the addressed register when the sixteenth synchronized clock rising edge is seen. Configuration outputs do not change at any other time.
- R3: On a read, SO presents the addressed byte MSB first during the second byte. SO changes only on synchronized falling edges of the serial clock while chip select is low, and it is low while chip select is high.
- R4: After reset, output level, direction and filter enable are all ones. Inversion, pull-up, interrupt enable, float, rising enable and falling enable are all zeros. SO is low.
- R5: Bit k of each register byte maps to pin k of the low byte, or to pin 8+k of the high byte. The MSB therefore maps to the highest pin of its byte.
- R6: A pin-state read returns, per pin, the pin value XOR the inversion bit when the direction bit is 1. When the direction bit is 0 it returns the stored output level, including when the pin is floated.
- R7: Writes to the pin-state registers, the interrupt status registers and addresses above 0x15 change nothing. Reads of addresses above 0x15 return 0x00.
- R8: A read of pin-state byte b asserts state_clr[b] for exactly one cycle once its command byte is complete. No other access pulses it.
- R9: If chip select rises before sixteen bits have been clocked in, no register is updated.
- R10: A read of the interrupt status pair returns the irq_status input for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idles low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| pin_in | input | 16 | Sampled pin values |
| irq_status | input | 16 | Per-pin interrupt status from the interrupt block |
| pin_is_input | output | 16 | Direction, 1 = input |
| pin_level | output | 16 | Output level per pin |
| pin_float | output | 16 | 1 = drive released (three-state) |
| pin_pullup | output | 16 | Pull-up enable |
| pin_invert | output | 16 | Input inversion enable |
| irq_enable | output | 16 | Interrupt enable |
| rise_enable | output | 16 | Rising-edge interrupt enable |
| fall_enable | output | 16 | Falling-edge interrupt enable |
| filter_enable | output | 16 | Input filter enable |
| state_clr | output | 2 | One-cycle clear strobe per pin-state byte read |

## Verification
The bench writes two complementary patterns to every writable address and checks both the mapped output bits and the value read back. A design that swapped the low and high bytes, or reversed bit order, fails at the ports. It sweeps direction, inversion, level and float against several pin patterns while reading the state bytes. A design that inverted output pins, or returned the pin value for an output, would return wrong bytes there. Writes to read-only and unmapped addresses, transfers cut short at 12 and 15 bits, and a command with its low bit set are each followed by port checks. A decoder that used bit 0, or committed on a partial frame, would change a register. Clear-strobe counters catch a strobe raised on the wrong byte, raised twice, or raised by a non-state read.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int ADDR_W = 6;
  localparam int NPAIR  = 11;

  typedef enum logic [4:0] {
    PR_STATE = 5'd0,
    PR_LEVEL = 5'd1,
    PR_INV   = 5'd2,
    PR_DIR   = 5'd3,
    PR_PULL  = 5'd4,
    PR_IEN   = 5'd5,
    PR_FLOAT = 5'd6,
    PR_STAT  = 5'd7,
    PR_RISE  = 5'd8,
    PR_FALL  = 5'd9,
    PR_FILT  = 5'd10
  } pair_e;

  function automatic logic pair_writable(input int p);
    return (p != int'(PR_STATE)) && (p != int'(PR_STAT));
  endfunction

  function automatic logic pair_rst_ones(input int p);
    return (p == int'(PR_LEVEL)) || (p == int'(PR_DIR)) || (p == int'(PR_FILT));
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/gpx_frame.sv
module gpx_frame
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              mosi_s,
  input  logic [7:0]        rd_data,
  output logic              cmd_stb,
  output logic              cmd_rd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_stb,
  output logic [7:0]        wr_data,
  output logic              miso
);
  localparam int FRAME_BITS = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic             sck_d;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh;
  logic [7:0]       tx;
  logic             rise_w, fall_w;
  logic [7:0]       byte_w;

  assign rise_w = sck_s & ~sck_d & ~csn_s;
  assign fall_w = ~sck_s & sck_d & ~csn_s;
  assign byte_w = {sh[6:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      cmd_stb  <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_addr <= '0;
      wr_stb   <= 1'b0;
      wr_data  <= '0;
      miso     <= 1'b0;
    end else begin
      sck_d   <= sck_s;
      cmd_stb <= 1'b0;
      wr_stb  <= 1'b0;
      if (csn_s) begin
        cnt  <= '0;
        miso <= 1'b0;
      end else begin
        if (rise_w && (int'(cnt) < FRAME_BITS)) begin
          sh  <= byte_w;
          cnt <= cnt + 1'b1;
          if (int'(cnt) == 7) begin
            cmd_rd   <= byte_w[7];
            cmd_addr <= byte_w[6:1];
            cmd_stb  <= 1'b1;
          end
          if ((int'(cnt) == FRAME_BITS - 1) && !cmd_rd) begin
            wr_stb  <= 1'b1;
            wr_data <= byte_w;
          end
        end
        if (cmd_stb) begin
          tx <= rd_data;
        end else if (fall_w && (int'(cnt) >= 8)) begin
          miso <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  // R3
  miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_w && !csn_s) |=> $stable(miso));
  // R3
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso);
  // R1
  cmd_vs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> !wr_stb);
  // R9
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(!csn_s));
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
  import gpx_pkg::*;
#(
  parameter  int NBYTES = 2,
  localparam int NPINS  = 8 * NBYTES,
  localparam int BW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cmd_stb,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  irq_status,
  output logic [7:0]        rd_data,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  level_o,
  output logic [NPINS-1:0]  float_o,
  output logic [NPINS-1:0]  pull_o,
  output logic [NPINS-1:0]  inv_o,
  output logic [NPINS-1:0]  ien_o,
  output logic [NPINS-1:0]  rise_o,
  output logic [NPINS-1:0]  fall_o,
  output logic [NPINS-1:0]  filt_o,
  output logic [NBYTES-1:0] state_clr
);
  localparam int NADDR = NPAIR * NBYTES;

  logic [NPINS-1:0] cfg_q [NPAIR];
  logic [4:0]       wr_pair, rd_pair;
  logic [BW-1:0]    wr_sel, rd_sel;
  logic             wr_in, rd_in;
  logic [NPINS-1:0] state_w, word_w;

  assign wr_pair = 5'(int'(wr_addr) / NBYTES);
  assign wr_sel  = BW'(int'(wr_addr) % NBYTES);
  assign wr_in   = int'(wr_addr) < NADDR;
  assign rd_pair = 5'(int'(rd_addr) / NBYTES);
  assign rd_sel  = BW'(int'(rd_addr) % NBYTES);
  assign rd_in   = int'(rd_addr) < NADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAIR; p++)
        cfg_q[p] <= pair_rst_ones(p) ? '1 : '0;
    end else if (wr_en && wr_in) begin
      for (int p = 0; p < NPAIR; p++)
        for (int b = 0; b < NBYTES; b++)
          if (pair_writable(p) && (int'(wr_pair) == p) && (int'(wr_sel) == b))
            cfg_q[p][b*8 +: 8] <= wr_data;
    end
  end

  assign level_o = cfg_q[PR_LEVEL];
  assign inv_o   = cfg_q[PR_INV];
  assign dir_o   = cfg_q[PR_DIR];
  assign pull_o  = cfg_q[PR_PULL];
  assign ien_o   = cfg_q[PR_IEN];
  assign float_o = cfg_q[PR_FLOAT];
  assign rise_o  = cfg_q[PR_RISE];
  assign fall_o  = cfg_q[PR_FALL];
  assign filt_o  = cfg_q[PR_FILT];

  // input pins: inverted-as-configured value; output pins: last written level
  assign state_w = (dir_o & (pin_in ^ inv_o)) | (~dir_o & level_o);

  always_comb begin
    word_w = '0;
    if (rd_pair == PR_STATE)     word_w = state_w;
    else if (rd_pair == PR_STAT) word_w = irq_status;
    else if (rd_in)              word_w = cfg_q[4'(rd_pair)];
  end

  assign rd_data = rd_in ? word_w[rd_sel*8 +: 8] : 8'h00;

  for (genvar b = 0; b < NBYTES; b++) begin : g_clr
    assign state_clr[b] = cmd_stb && cmd_rd && (rd_pair == PR_STATE) && (int'(rd_sel) == b);
  end

  // R8
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(state_clr));
  // R8
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_clr != '0) |=> (state_clr == '0));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({dir_o, level_o, float_o, pull_o, inv_o, ien_o, rise_o, fall_o, filt_o}));
  // R7
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (!wr_in || wr_pair == PR_STATE || wr_pair == PR_STAT))
      |=> $stable({dir_o, level_o, float_o, pull_o, inv_o, ien_o, rise_o, fall_o, filt_o}));
endmodule

// File: rtl/spi_gpio_ctrl.sv
module spi_gpio_ctrl
  import gpx_pkg::*;
#(
  parameter  int NBYTES      = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int NPINS       = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  irq_status,
  output logic [NPINS-1:0]  pin_is_input,
  output logic [NPINS-1:0]  pin_level,
  output logic [NPINS-1:0]  pin_float,
  output logic [NPINS-1:0]  pin_pullup,
  output logic [NPINS-1:0]  pin_invert,
  output logic [NPINS-1:0]  irq_enable,
  output logic [NPINS-1:0]  rise_enable,
  output logic [NPINS-1:0]  fall_enable,
  output logic [NPINS-1:0]  filter_enable,
  output logic [NBYTES-1:0] state_clr
);
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]        raw, synced;
  logic              cmd_stb, cmd_rd, wr_stb;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        wr_data, rd_data;

  assign raw = {spi_csn, spi_mosi, spi_sck};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    gpx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[i])) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(synced[i]));
  end

  gpx_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sck_s(synced[0]), .csn_s(synced[2]), .mosi_s(synced[1]),
    .rd_data(rd_data),
    .cmd_stb(cmd_stb), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .miso(spi_miso));

  gpx_regs #(.NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_stb), .wr_addr(cmd_addr), .wr_data(wr_data),
    .cmd_stb(cmd_stb), .cmd_rd(cmd_rd), .rd_addr(cmd_addr),
    .pin_in(pin_in), .irq_status(irq_status), .rd_data(rd_data),
    .dir_o(pin_is_input), .level_o(pin_level), .float_o(pin_float),
    .pull_o(pin_pullup), .inv_o(pin_invert), .ien_o(irq_enable),
    .rise_o(rise_enable), .fall_o(fall_enable), .filt_o(filter_enable),
    .state_clr(state_clr));

  // R8
  clr_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_clr != '0) |-> (cmd_stb && cmd_rd));
endmodule

// File: tb/sim_spi_gpio_ctrl.sv
module sim_spi_gpio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [15:0] pin_in = 16'h0, irq_status = 16'h0;
  logic [15:0] is_in, level, flt, pull, inv, ien, rise, fall, filt;
  logic [1:0]  clr;

  int n_checks = 0, n_fail = 0, c0 = 0, c1 = 0;
  logic [7:0] m [22];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_gpio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .pin_in(pin_in), .irq_status(irq_status),
    .pin_is_input(is_in), .pin_level(level), .pin_float(flt), .pin_pullup(pull),
    .pin_invert(inv), .irq_enable(ien), .rise_enable(rise), .fall_enable(fall),
    .filter_enable(filt), .state_clr(clr));

  always @(posedge clk) begin
    if (clr[0]) c0++;
    if (clr[1]) c1++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [7:0] cmd, input logic [7:0] din, input int nbits,
                          output logic [7:0] dout);
    dout = 8'h00;
    csn = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? cmd[7-i] : din[15-i];
      tick(HALF);
      if (i >= 8) dout[15-i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    csn = 1'b1;
    tick(2*HALF);
  endtask

  function automatic logic writable(input int a);
    return (a >= 2 && a <= 13) || (a >= 16 && a <= 21);
  endfunction

  function automatic logic [15:0] vec(input int p);
    return {m[2*p+1], m[2*p]};
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    logic [15:0] st;
    if (a >= 22) return 8'h00;
    st = (vec(3) & (pin_in ^ vec(2))) | (~vec(3) & vec(1));
    if (a / 2 == 0) return (a % 2) ? st[15:8] : st[7:0];
    if (a / 2 == 7) return (a % 2) ? irq_status[15:8] : irq_status[7:0];
    return m[a];
  endfunction

  task automatic write_reg(input int a, input logic [7:0] v);
    logic [7:0] d;
    spi_xfer({1'b0, 6'(a), 1'b0}, v, 16, d);
    if (writable(a)) m[a] = v;
  endtask

  task automatic read_reg(input int a, output logic [7:0] d);
    spi_xfer({1'b1, 6'(a), 1'b0}, 8'h00, 16, d);
  endtask

  task automatic check_ports(input string req);
    check({req, " level"},  level, vec(1));
    check({req, " invert"}, inv,   vec(2));
    check({req, " dir"},    is_in, vec(3));
    check({req, " pullup"}, pull,  vec(4));
    check({req, " ien"},    ien,   vec(5));
    check({req, " float"},  flt,   vec(6));
    check({req, " rise"},   rise,  vec(8));
    check({req, " fall"},   fall,  vec(9));
    check({req, " filter"}, filt,  vec(10));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int a = 0; a < 22; a++) m[a] = 8'h00;
    m[2] = 8'hFF; m[3] = 8'hFF; m[6] = 8'hFF; m[7] = 8'hFF; m[20] = 8'hFF; m[21] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R4 reset state at the ports
    check_ports("R4 reset");
    check("R4 miso idle", {15'h0, miso}, 16'h0);
    check("R8 no strobe at reset", {14'h0, clr}, 16'h0);

    // R4 R6 R10 readback of every address after reset
    pin_in = 16'hA5C3;
    irq_status = 16'h1234;
    for (int a = 0; a < 22; a++) begin
      read_reg(a, d);
      check($sformatf("R4 R6 R10 reset read addr %0d", a), {8'h0, d}, {8'h0, exp_rd(a)});
    end
    check("R8 one strobe per state byte (low)", 16'(c0), 16'd1);
    check("R8 one strobe per state byte (high)", 16'(c1), 16'd1);

    // R2 R3 R5 two complementary patterns on every writable address
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 2; a < 22; a++) begin
        if (writable(a)) begin
          logic [7:0] v;
          v = 8'((a * 37 + 11) ^ 8'h96);
          if (pass == 1) v = ~v;
          write_reg(a, v);
          check_ports($sformatf("R2 R5 write addr %0d", a));
          read_reg(a, d);
          check($sformatf("R3 readback addr %0d", a), {8'h0, d}, {8'h0, v});
        end
      end
    end

    // R7 writes to read-only and unmapped addresses
    begin
      int ro [6] = '{0, 1, 14, 15, 22, 63};
      foreach (ro[k]) begin
        write_reg(ro[k], 8'h5A);
        check_ports($sformatf("R7 write addr %0d ignored", ro[k]));
      end
    end
    read_reg(22, d);
    check("R7 unmapped read", {8'h0, d}, 16'h0);
    read_reg(63, d);
    check("R7 unmapped read top", {8'h0, d}, 16'h0);

    // R1 bit 0 of the command has no effect
    spi_xfer({1'b0, 6'd4, 1'b1}, 8'h3C, 16, d);
    m[4] = 8'h3C;
    check_ports("R1 cmd bit0 write");
    spi_xfer({1'b1, 6'd4, 1'b1}, 8'h00, 16, d);
    check("R1 cmd bit0 read", {8'h0, d}, 16'h003C);

    // R9 aborted frames leave registers untouched
    spi_xfer({1'b0, 6'd2, 1'b0}, 8'h00, 12, d);
    check_ports("R9 abort at 12 bits");
    spi_xfer({1'b0, 6'd9, 1'b0}, 8'h00, 15, d);
    check_ports("R9 abort at 15 bits");
    read_reg(9, d);
    check("R9 readback after abort", {8'h0, d}, {8'h0, m[9]});

    // R6 R8 state merge sweep
    for (int k = 0; k < 4; k++) begin
      logic [15:0] dv, pv, ov, tv;
      dv = 16'(k * 16'h4B2D) ^ 16'hF00F;
      pv = 16'(k * 16'h1357) ^ 16'h0FF0;
      ov = 16'(k * 16'h7A31);
      tv = (k % 2 == 1) ? 16'hFFFF : 16'h0000;
      write_reg(6, dv[7:0]);  write_reg(7, dv[15:8]);
      write_reg(4, pv[7:0]);  write_reg(5, pv[15:8]);
      write_reg(2, ov[7:0]);  write_reg(3, ov[15:8]);
      write_reg(12, tv[7:0]); write_reg(13, tv[15:8]);
      for (int j = 0; j < 4; j++) begin
        int s0, s1;
        pin_in = 16'(j * 16'h5A69 + k * 16'h0101);
        s0 = c0; s1 = c1;
        read_reg(0, d);
        check($sformatf("R6 state low k%0d j%0d", k, j), {8'h0, d}, {8'h0, exp_rd(0)});
        check("R8 low strobe count", 16'(c0 - s0), 16'd1);
        check("R8 high strobe untouched", 16'(c1 - s1), 16'd0);
        read_reg(1, d);
        check($sformatf("R6 state high k%0d j%0d", k, j), {8'h0, d}, {8'h0, exp_rd(1)});
        check("R8 high strobe count", 16'(c1 - s1), 16'd1);
      end
    end

    // R10 R8 status read does not strobe
    begin
      int s0, s1;
      irq_status = 16'hBEEF;
      s0 = c0; s1 = c1;
      read_reg(15, d);
      check("R10 status high", {8'h0, d}, 16'h00BE);
      read_reg(14, d);
      check("R10 status low", {8'h0, d}, 16'h00EF);
      check("R8 no strobe on status read", 16'((c0 - s0) + (c1 - s1)), 16'd0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule